// File: doc/BRIEF.md
# Parity-Checked Byte Port with Overrun Detection

This block connects a processor bus to a simple byte-wide peripheral. A processor access is taken only when its address matches the port's base and the space qualifier marks it as an I/O access rather than a memory access. The read and write strobes, together with address bit 0, pick one of four registers. Reads reach a receive buffer or a status byte. Writes reach a transmit buffer or a control byte.

On the device side, received bytes arrive with a parity bit under a valid strobe. Each byte is checked against the parity sense chosen in the control byte. Outgoing bytes are offered with a valid strobe and a computed parity bit until the device signals that it has taken them. Sticky status flags record parity errors, input overruns and output overruns. Reading the status byte clears these flags.

Top module: `pio_port`

## Requirements
- R1: A register is accessed only when `bus_io_i`=1 and `bus_addr_i[ADDR_W-1:1]` equals `BASE_ADDR[ADDR_W-1:1]`. Any other access reads as zero and leaves all state unchanged.
- R2: A read with rd=1, wr=0 returns the receive buffer when A0=0 and the status byte when A0=1, on `bus_rdata_o` in the same cycle. If rd and wr are both 1, nothing is accessed and the read data is zero.
- R3: A write with wr=1, rd=0 loads the transmit buffer when A0=0 and the control byte when A0=1, at the next rising edge. Control bit 0 selects the parity sense: 1 is odd, 0 is even.
- R4: The status byte has bit 0 rx-full, bit 1 tx-empty, bit 2 parity error, bit 3 input overrun and bit 4 output overrun; bits 7..5 are zero. After reset it reads 0x02.
- R5: A received byte is in error when the number of ones in the data and parity bit together is odd while even parity is selected, or even while odd parity is selected. An error sets status bit 2 from the next cycle.
- R6: A received byte is stored and sets rx-full from the next cycle. Reading the receive buffer clears rx-full from the next cycle, unless a new byte arrives in the same cycle.
- R7: If a byte arrives while rx-full is set and the buffer is not read in that cycle, status bit 3 sets and the newer byte replaces the stored one.
- R8: A transmit-buffer write raises `dev_tx_valid_o` with the byte from the next cycle and clears tx-empty. `dev_tx_taken_i` while valid drops valid and sets tx-empty from the next cycle. `dev_tx_taken_i` while not valid has no effect.
- R9: If the transmit buffer is written while valid is set and the device does not take the byte in that cycle, status bit 4 sets and the newer byte replaces the pending one. A write in the same cycle as a take sets no flag.
- R10: `dev_tx_par_o` follows the current control parity sense, so that data plus parity bit has an even count of ones in even mode and an odd count in odd mode.
- R11: The error flags (bits 2..4) stay set until the status byte is read, and they clear from the cycle after that read. An error event in the same cycle as the read leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_io_i | input | 1 | 1 = I/O-space access, 0 = memory access |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, zero when no read is selected |
| dev_rx_valid_i | input | 1 | Received byte present |
| dev_rx_data_i | input | DATA_W | Received byte |
| dev_rx_par_i | input | 1 | Received parity bit |
| dev_tx_valid_o | output | 1 | Outgoing byte pending |
| dev_tx_data_o | output | DATA_W | Outgoing byte |
| dev_tx_par_o | output | 1 | Outgoing parity bit |
| dev_tx_taken_i | input | 1 | Device accepts the pending byte |

## Verification
Read data and the outgoing parity bit are combinational, so they are due in the same cycle as the stimulus. Buffer loads, rx-full, tx-empty, valid and every flag change appear one rising edge after the stimulus that causes them. The bench drives each stimulus at a falling edge and holds its strobes across exactly one rising edge. It samples the combinational outputs 1 ns after driving and checks registered effects in the next stimulus slot, so each expected value is read one edge after its cause. Same-cycle collisions are driven as one combined stimulus: read with arrival, status read with parity error, and write with take.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int ST_RX_FULL  = 0;
  localparam int ST_TX_EMPTY = 1;
  localparam int ST_PAR_ERR  = 2;
  localparam int ST_OVR_IN   = 3;
  localparam int ST_OVR_OUT  = 4;
  localparam int ST_BITS     = 5;

  typedef struct packed {
    logic rd_data;
    logic rd_stat;
    logic wr_data;
    logic wr_ctrl;
  } pio_sel_t;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output pio_sel_t          sel_o
);
  logic hit, rd_only, wr_only, a0;

  assign hit     = io_i && (addr_i[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign rd_only = hit & rd_i & ~wr_i;
  assign wr_only = hit & wr_i & ~rd_i;
  assign a0      = addr_i[0];

  assign sel_o.rd_data = rd_only & ~a0;
  assign sel_o.rd_stat = rd_only &  a0;
  assign sel_o.wr_data = wr_only & ~a0;
  assign sel_o.wr_ctrl = wr_only &  a0;

  p_onehot_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_o.rd_data, sel_o.rd_stat, sel_o.wr_data, sel_o.wr_ctrl}));
endmodule

// File: rtl/pio_rx.sv
module pio_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              odd_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              rd_data_i,
  input  logic              clr_err_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              full_o,
  output logic              par_err_o,
  output logic              ovr_o
);
  logic bad;
  assign bad = ((^data_i) ^ par_i) != odd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o     <= '0;
      full_o    <= 1'b0;
      par_err_o <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      if (valid_i) buf_o <= data_i;

      if (valid_i)        full_o <= 1'b1;
      else if (rd_data_i) full_o <= 1'b0;

      // a new event wins over a clear in the same cycle
      if (valid_i && bad) par_err_o <= 1'b1;
      else if (clr_err_i) par_err_o <= 1'b0;

      if (valid_i && full_o && !rd_data_i) ovr_o <= 1'b1;
      else if (clr_err_i)                  ovr_o <= 1'b0;
    end
  end

  p_par_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bad) |=> par_err_o);
  p_ovr_in_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && full_o && !rd_data_i) |=> (ovr_o && full_o));
  p_full_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !valid_i) |=> !full_o);
endmodule

// File: rtl/pio_tx.sv
module pio_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              odd_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              taken_i,
  input  logic              clr_err_i,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o,
  output logic              valid_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (wr_data_i) data_o <= wdata_i;

      if (wr_data_i)    valid_o <= 1'b1;
      else if (taken_i) valid_o <= 1'b0;

      if (wr_data_i && valid_o && !taken_i) ovr_o <= 1'b1;
      else if (clr_err_i)                   ovr_o <= 1'b0;
    end
  end

  // parity follows the live control setting at send time
  assign par_o = (^data_o) ^ odd_i;

  p_tx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_i && !wr_data_i) |=> (valid_o && $stable(data_o)));
  p_tx_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_i && !wr_data_i) |=> !valid_o);
  p_ovr_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && valid_o && !taken_i) |=> ovr_o);
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_io_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              dev_rx_valid_i,
  input  logic [DATA_W-1:0] dev_rx_data_i,
  input  logic              dev_rx_par_i,
  output logic              dev_tx_valid_o,
  output logic [DATA_W-1:0] dev_tx_data_o,
  output logic              dev_tx_par_o,
  input  logic              dev_tx_taken_i
);
  localparam int PAD_W = DATA_W - ST_BITS;

  pio_sel_t            sel;
  logic                odd_q;
  logic [DATA_W-1:0]   rx_buf;
  logic                rx_full, par_err, ovr_in, ovr_out;
  logic [ST_BITS-1:0]  stat_bits;
  logic [DATA_W-1:0]   status;

  pio_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (bus_addr_i),
    .io_i   (bus_io_i),
    .rd_i   (bus_rd_i),
    .wr_i   (bus_wr_i),
    .sel_o  (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          odd_q <= 1'b0;
    else if (sel.wr_ctrl) odd_q <= bus_wdata_i[0];
  end

  pio_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .odd_i     (odd_q),
    .valid_i   (dev_rx_valid_i),
    .data_i    (dev_rx_data_i),
    .par_i     (dev_rx_par_i),
    .rd_data_i (sel.rd_data),
    .clr_err_i (sel.rd_stat),
    .buf_o     (rx_buf),
    .full_o    (rx_full),
    .par_err_o (par_err),
    .ovr_o     (ovr_in)
  );

  pio_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .odd_i     (odd_q),
    .wr_data_i (sel.wr_data),
    .wdata_i   (bus_wdata_i),
    .taken_i   (dev_tx_taken_i),
    .clr_err_i (sel.rd_stat),
    .data_o    (dev_tx_data_o),
    .par_o     (dev_tx_par_o),
    .valid_o   (dev_tx_valid_o),
    .ovr_o     (ovr_out)
  );

  always_comb begin
    stat_bits              = '0;
    stat_bits[ST_RX_FULL]  = rx_full;
    stat_bits[ST_TX_EMPTY] = ~dev_tx_valid_o;
    stat_bits[ST_PAR_ERR]  = par_err;
    stat_bits[ST_OVR_IN]   = ovr_in;
    stat_bits[ST_OVR_OUT]  = ovr_out;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign status = {{PAD_W{1'b0}}, stat_bits};
    end else begin : g_nopad
      assign status = stat_bits[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (1'b1)
      sel.rd_data: bus_rdata_o = rx_buf;
      sel.rd_stat: bus_rdata_o = status;
      default:     bus_rdata_o = '0;
    endcase
  end

  p_mem_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_io_i |-> (bus_rdata_o == '0));
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel.rd_stat && !dev_rx_valid_i) |=> (!par_err && !ovr_in && !ovr_out));
  p_txpar_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_tx_valid_o |-> ((^{dev_tx_data_o, dev_tx_par_o}) == odd_q));
  p_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[ST_TX_EMPTY] == !dev_tx_valid_o);
endmodule

// File: tb/pio_port_tb.sv
`timescale 1ns/1ps
module pio_port_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_RX = 3'd2,
                         OP_TAKE = 3'd3, OP_TX = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic       io;
    logic [7:0] addr;
    logic [7:0] data;
    logic       par;
    logic [9:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 34;
  // exp for OP_RD is read data; for OP_TX it is {valid, parity, data}
  localparam vec_t VEC [NV] = '{
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h002, 4'd4},  // R4 reset status
    '{OP_RX,   1'b1, 8'h00, 8'h35, 1'b0, 10'h000, 4'd6},
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h003, 4'd6},  // R6 rx-full set
    '{OP_RD,   1'b1, 8'h40, 8'h00, 1'b0, 10'h035, 4'd2},  // R2 data-in read
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h002, 4'd6},  // R6 rx-full cleared
    '{OP_RX,   1'b1, 8'h00, 8'h07, 1'b0, 10'h000, 4'd5},  // R5 bad even parity
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h007, 4'd5},
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h003, 4'd11}, // R11 cleared by read
    '{OP_RX,   1'b1, 8'h00, 8'h80, 1'b1, 10'h000, 4'd7},  // R7 arrives while full
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h00B, 4'd7},
    '{OP_RD,   1'b1, 8'h40, 8'h00, 1'b0, 10'h080, 4'd7},  // newer byte kept
    '{OP_WR,   1'b1, 8'h41, 8'h01, 1'b0, 10'h000, 4'd3},  // R3 odd parity
    '{OP_RX,   1'b1, 8'h00, 8'h07, 1'b0, 10'h000, 4'd5},
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h003, 4'd5},  // good in odd mode
    '{OP_RD,   1'b1, 8'h40, 8'h00, 1'b0, 10'h007, 4'd2},
    '{OP_WR,   1'b1, 8'h40, 8'hA5, 1'b0, 10'h000, 4'd8},  // R8
    '{OP_TX,   1'b1, 8'h00, 8'h00, 1'b0, 10'h3A5, 4'd10}, // R10 odd parity out
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h000, 4'd8},
    '{OP_WR,   1'b1, 8'h40, 8'h3C, 1'b0, 10'h000, 4'd9},  // R9 overwrite pending
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h010, 4'd9},
    '{OP_TX,   1'b1, 8'h00, 8'h00, 1'b0, 10'h33C, 4'd9},
    '{OP_WR,   1'b1, 8'h41, 8'h00, 1'b0, 10'h000, 4'd3},
    '{OP_TX,   1'b1, 8'h00, 8'h00, 1'b0, 10'h23C, 4'd10}, // live parity change
    '{OP_TAKE, 1'b1, 8'h00, 8'h00, 1'b0, 10'h000, 4'd8},
    '{OP_TX,   1'b1, 8'h00, 8'h00, 1'b0, 10'h03C, 4'd8},
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h002, 4'd8},
    '{OP_RD,   1'b0, 8'h41, 8'h00, 1'b0, 10'h000, 4'd1},  // R1 memory space
    '{OP_WR,   1'b0, 8'h40, 8'h55, 1'b0, 10'h000, 4'd1},
    '{OP_TX,   1'b1, 8'h00, 8'h00, 1'b0, 10'h03C, 4'd1},
    '{OP_WR,   1'b1, 8'h50, 8'h55, 1'b0, 10'h000, 4'd1},  // R1 other address
    '{OP_TX,   1'b1, 8'h00, 8'h00, 1'b0, 10'h03C, 4'd1},
    '{OP_RD,   1'b1, 8'h50, 8'h00, 1'b0, 10'h000, 4'd1},
    '{OP_TAKE, 1'b1, 8'h00, 8'h00, 1'b0, 10'h000, 4'd8},  // R8 take while idle
    '{OP_RD,   1'b1, 8'h41, 8'h00, 1'b0, 10'h002, 4'd8}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic          bus_io_i = 1'b0, bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [DW-1:0] bus_wdata_i = '0;
  logic [DW-1:0] bus_rdata_o;
  logic          dev_rx_valid_i = 1'b0;
  logic [DW-1:0] dev_rx_data_i = '0;
  logic          dev_rx_par_i = 1'b0;
  logic          dev_tx_valid_o;
  logic [DW-1:0] dev_tx_data_o;
  logic          dev_tx_par_o;
  logic          dev_tx_taken_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] rdata_s;
  logic [9:0]    tx_s;

  always #4 clk_i = ~clk_i;

  pio_port #(.ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(8'h40)) u_dut (.*);

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one stimulus slot: drive at falling edge, sample 1 ns later, hold one rising edge
  task automatic cyc(input logic rd, input logic wr, input logic io, input logic [7:0] addr,
                     input logic [7:0] wd, input logic rxv, input logic [7:0] rxd,
                     input logic rxp, input logic take);
    @(negedge clk_i);
    bus_rd_i = rd; bus_wr_i = wr; bus_io_i = io; bus_addr_i = addr; bus_wdata_i = wd;
    dev_rx_valid_i = rxv; dev_rx_data_i = rxd; dev_rx_par_i = rxp; dev_tx_taken_i = take;
    #1;
    rdata_s = bus_rdata_o;
    tx_s    = {dev_tx_valid_o, dev_tx_par_o, dev_tx_data_o};
    @(posedge clk_i);
    #1;
    bus_rd_i = 1'b0; bus_wr_i = 1'b0; bus_io_i = 1'b0; dev_rx_valid_i = 1'b0;
    dev_tx_taken_i = 1'b0;
  endtask

  task automatic idle_cyc();
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic rd_reg(input logic [7:0] addr);
    cyc(1'b1, 1'b0, 1'b1, addr, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      string tag = $sformatf("R%0d vec %0d", v.req, i);
      case (v.op)
        OP_RD:   begin
          cyc(1'b1, 1'b0, v.io, v.addr, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
          check(tag, {2'b00, rdata_s}, v.exp);
        end
        OP_WR:   cyc(1'b0, 1'b1, v.io, v.addr, v.data, 1'b0, 8'h00, 1'b0, 1'b0);
        OP_RX:   cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, v.data, v.par, 1'b0);
        OP_TAKE: cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
        default: begin
          idle_cyc();
          check(tag, tx_s, v.exp);
        end
      endcase
    end

    // R6 R7: read of data-in in the same cycle as an arrival
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 8'h40, 8'h00, 1'b1, 8'h22, 1'b0, 1'b0);
    check("R6 old byte on read", {2'b00, rdata_s}, 10'h011);
    rd_reg(8'h41);
    check("R7 no overrun when read same cycle", {2'b00, rdata_s}, 10'h003);
    rd_reg(8'h40);
    check("R6 new byte stored", {2'b00, rdata_s}, 10'h022);

    // R11: parity error in the same cycle as a status read survives the clear
    cyc(1'b1, 1'b0, 1'b1, 8'h41, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0);
    check("R11 status before event", {2'b00, rdata_s}, 10'h002);
    rd_reg(8'h41);
    check("R11 set wins over clear", {2'b00, rdata_s}, 10'h007);
    rd_reg(8'h41);
    check("R11 cleared afterwards", {2'b00, rdata_s}, 10'h003);
    rd_reg(8'h40);

    // R9: write in the same cycle as take gives no overrun
    cyc(1'b0, 1'b1, 1'b1, 8'h40, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 8'h40, 8'h02, 1'b0, 8'h00, 1'b0, 1'b1);
    idle_cyc();
    check("R9 byte after write+take", tx_s, 10'h302);
    rd_reg(8'h41);
    check("R9 no output overrun", {2'b00, rdata_s}, 10'h000);

    // R2: rd and wr together select nothing
    cyc(1'b1, 1'b1, 1'b1, 8'h40, 8'h77, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R2 rd+wr reads zero", {2'b00, rdata_s}, 10'h000);
    idle_cyc();
    check("R2 rd+wr writes nothing", tx_s, 10'h302);

    // R4: asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R4 tx idle in reset", {9'b0, dev_tx_valid_o}, 10'h000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_reg(8'h41);
    check("R4 status after reset", {2'b00, rdata_s}, 10'h002);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule